// File: doc/BRIEF.md
# Receive Clock-Compensation Buffer

This block sits between a receive decoder and the rest of a receive datapath. Characters arrive on the clock recovered from the line. Each character is eight data bits plus a control flag. The block delivers them on the local reference clock. The two clocks run at nominally the same rate but drift apart by a small offset. A 16-entry dual-clock store absorbs that offset. The store tries to stay half full. When it drifts high, it discards an incoming framing character (the K28.5 comma: control flag set, data 0xBC). When it drifts low, it repeats a framing character on the way out. Data characters are never touched.

Read and write pointers cross between the domains as gray codes through two-stage synchronizers. Each side computes its own fill level from its own pointer and the synchronized copy of the other pointer. If the store runs dry, commas are produced and a sticky underflow flag is raised. If it runs full, an arriving data character is discarded and a sticky overflow flag is raised.

Setting the bypass input routes the incoming characters straight to the output through one register on the recovered clock.

Top module: `rx_elastic_buf`

## Requirements
- R1: While reset is applied and just after it is released, the output carries the comma (char_k_o=1, char_d_o=0xBC) and both flags are low. The store starts out holding eight commas, with the write pointer eight ahead of the read pointer.
- R2: In buffered mode, with no overflow, the non-comma characters leave in the same order in which they arrived. None is lost and none is repeated.
- R3: Each pointer is passed across clock domains as a gray code. It changes by at most one bit per clock of its own domain.
- R4: An arriving comma is not stored when the write-side fill is above 10. A non-comma is always stored unless the write-side fill is 16. With the recovered clock 2.5% faster than the reference clock and commas in the stream, no overflow occurs.
- R5: Suppose a comma is read while the read-side fill is below 6. Then the next output cycle repeats a comma without advancing the read pointer. This happens at most once per comma read. With the recovered clock 2.5% slower and commas in the stream, no underflow occurs.
- R6: When the read side sees an empty store, the output is a comma and underflow_o goes high. It stays high until reset.
- R7: The write-side fill never exceeds 16. When it is 16, an arriving non-comma is discarded, stored characters are kept, and overflow_o goes high until reset.
- R8: With bypass_i high, the output equals the input character captured at the previous rising edge of wclk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Recovered (write) clock |
| rclk_i | input | 1 | Local reference (read) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bypass_i | input | 1 | High: skip the buffer, output timed by wclk_i |
| char_k_i | input | 1 | Control flag of the incoming character |
| char_d_i | input | 8 | Data bits of the incoming character |
| char_k_o | output | 1 | Control flag of the outgoing character |
| char_d_o | output | 8 | Data bits of the outgoing character |
| underflow_o | output | 1 | Sticky: the read side found the store empty |
| overflow_o | output | 1 | Sticky: a data character arrived with the store full |

## Verification
A corrupted pointer or a wrong fill computation shows up at the output first as a data character that is out of order, repeated or missing. This appears within one pass through the store, which is at most 16 reference-clock cycles. A rate-matching decision that is wrong, or never taken, shows up more slowly. Under a sustained 2.5% clock offset, the store saturates within a few hundred cycles, and the sticky underflow or overflow flag then rises and stays up. A broken bypass path is visible on the very next recovered-clock edge.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } char_t;

  localparam char_t COMMA = '{k: 1'b1, d: 8'hBC};
endpackage

// File: rtl/ebuf_rst_sync.sv
module ebuf_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};

  assign rst_no = stg_q[1];
endmodule

// File: rtl/ebuf_ptr_sync.sv
module ebuf_ptr_sync #(
  parameter int unsigned    W       = 5,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end

  assign q_o = s2_q;
endmodule

// File: rtl/ebuf_wr_ctl.sv
module ebuf_wr_ctl
  import ebuf_pkg::*;
#(
  parameter int unsigned AW      = 4,
  parameter int unsigned FILL_HI = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  char_t           char_i,
  input  logic [AW:0]     rgray_i,
  output logic            we_o,
  output logic [AW-1:0]   waddr_o,
  output logic [AW:0]     wgray_o,
  output logic [AW:0]     fill_o,
  output logic            ovf_o
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [PW-1:0] FULL_V = PW'(DEPTH);
  localparam logic [PW-1:0] HI_V   = PW'(FILL_HI);
  localparam logic [PW-1:0] HALF_V = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wptr_q, wgray_q, wptr_nx;
  logic          is_comma, full, drop_comma;

  assign fill_o     = wptr_q - g2b(rgray_i);
  assign full       = (fill_o == FULL_V);
  assign is_comma   = (char_i == COMMA);
  // rate match: shed a comma when running high
  assign drop_comma = is_comma && (fill_o > HI_V);
  assign we_o       = !drop_comma && !full;
  assign wptr_nx    = wptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wptr_q  <= HALF_V;
      wgray_q <= HALF_V ^ (HALF_V >> 1);
      ovf_o   <= 1'b0;
    end else begin
      if (we_o) begin
        wptr_q  <= wptr_nx;
        wgray_q <= wptr_nx ^ (wptr_nx >> 1);
      end
      if (!drop_comma && full) ovf_o <= 1'b1;
    end

  assign waddr_o = wptr_q[AW-1:0];
  assign wgray_o = wgray_q;
endmodule

// File: rtl/ebuf_rd_ctl.sv
module ebuf_rd_ctl
  import ebuf_pkg::*;
#(
  parameter int unsigned AW      = 4,
  parameter int unsigned FILL_LO = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW:0]     wgray_i,
  input  char_t           rdata_i,
  output logic [AW-1:0]   raddr_o,
  output logic [AW:0]     rgray_o,
  output logic [AW:0]     fill_o,
  output char_t           char_o,
  output logic            ins_o,
  output logic            unf_o
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] LO_V = PW'(FILL_LO);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rptr_q, rgray_q, rptr_nx;
  logic          empty;

  assign fill_o  = g2b(wgray_i) - rptr_q;
  assign empty   = (fill_o == '0);
  assign rptr_nx = rptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      char_o  <= COMMA;
      ins_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else if (ins_o) begin
      // repeat the comma just sent, hold pointer
      char_o <= COMMA;
      ins_o  <= 1'b0;
    end else if (empty) begin
      char_o <= COMMA;
      unf_o  <= 1'b1;
    end else begin
      char_o  <= rdata_i;
      rptr_q  <= rptr_nx;
      rgray_q <= rptr_nx ^ (rptr_nx >> 1);
      ins_o   <= (rdata_i == COMMA) && (fill_o < LO_V);
    end

  assign raddr_o = rptr_q[AW-1:0];
  assign rgray_o = rgray_q;
endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
  import ebuf_pkg::*;
#(
  parameter int unsigned AW      = 4,
  parameter int unsigned FILL_LO = 6,
  parameter int unsigned FILL_HI = 10
) (
  input  logic       wclk_i,
  input  logic       rclk_i,
  input  logic       rst_ni,
  input  logic       bypass_i,
  input  logic       char_k_i,
  input  logic [7:0] char_d_i,
  output logic       char_k_o,
  output logic [7:0] char_d_o,
  output logic       underflow_o,
  output logic       overflow_o
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [PW-1:0] HALF_V = PW'(DEPTH / 2);
  localparam logic [PW-1:0] HALF_G = HALF_V ^ (HALF_V >> 1);

  logic          wrst_n, rrst_n, we, rd_ins;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s, wfill, rfill;
  char_t         wr_char, rd_char, mem_rd, byp_q, out_char;
  char_t         mem_q [DEPTH];

  assign wr_char = '{k: char_k_i, d: char_d_i};

  ebuf_rst_sync i_wrst (.clk_i(wclk_i), .rst_ni(rst_ni), .rst_no(wrst_n));
  ebuf_rst_sync i_rrst (.clk_i(rclk_i), .rst_ni(rst_ni), .rst_no(rrst_n));

  ebuf_ptr_sync #(.W(PW), .RST_VAL('0)) i_rptr_sync (
    .clk_i(wclk_i), .rst_ni(wrst_n), .d_i(rgray), .q_o(rgray_s));
  ebuf_ptr_sync #(.W(PW), .RST_VAL(HALF_G)) i_wptr_sync (
    .clk_i(rclk_i), .rst_ni(rrst_n), .d_i(wgray), .q_o(wgray_s));

  ebuf_wr_ctl #(.AW(AW), .FILL_HI(FILL_HI)) i_wr_ctl (
    .clk_i(wclk_i), .rst_ni(wrst_n), .char_i(wr_char), .rgray_i(rgray_s),
    .we_o(we), .waddr_o(waddr), .wgray_o(wgray), .fill_o(wfill), .ovf_o(overflow_o));

  ebuf_rd_ctl #(.AW(AW), .FILL_LO(FILL_LO)) i_rd_ctl (
    .clk_i(rclk_i), .rst_ni(rrst_n), .wgray_i(wgray_s), .rdata_i(mem_rd),
    .raddr_o(raddr), .rgray_o(rgray), .fill_o(rfill), .char_o(rd_char),
    .ins_o(rd_ins), .unf_o(underflow_o));

  // storage preloaded with commas so the initial half-fill reads clean
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge wclk_i or negedge wrst_n)
      if (!wrst_n)                       mem_q[e] <= COMMA;
      else if (we && waddr == AW'(e))    mem_q[e] <= wr_char;
  end

  assign mem_rd = mem_q[raddr];

  always_ff @(posedge wclk_i or negedge wrst_n)
    if (!wrst_n) byp_q <= COMMA;
    else         byp_q <= wr_char;

  assign out_char = bypass_i ? byp_q : rd_char;
  assign char_k_o = out_char.k;
  assign char_d_o = out_char.d;
endmodule

// File: rtl/ebuf_chk.sv
module ebuf_chk
  import ebuf_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input logic        wclk_i,
  input logic        rclk_i,
  input logic        wrst_n,
  input logic        rrst_n,
  input char_t       wr_char,
  input char_t       rd_char,
  input logic [AW:0] wgray,
  input logic [AW:0] rgray,
  input logic [AW:0] wfill,
  input logic [AW:0] rfill,
  input logic        rd_ins,
  input logic        underflow_o,
  input logic        overflow_o
);
  localparam logic [AW:0] FULL_V = (AW+1)'(1 << AW);

  a_r3_wgray_step: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    $onehot0(wgray ^ $past(wgray)));
  a_r3_rgray_step: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    $onehot0(rgray ^ $past(rgray)));
  a_r4_keep_data: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    (wfill != FULL_V && wr_char != COMMA) |=> (wgray != $past(wgray)));
  a_r5_ins_after_comma: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    rd_ins |-> (rd_char == COMMA));
  a_r5_single_ins: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    rd_ins |=> !rd_ins);
  a_r6_empty_comma: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    (rfill == '0 && !rd_ins) |=> (rd_char == COMMA && underflow_o));
  a_r6_sticky: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    underflow_o |=> underflow_o);
  a_r7_fill_bound: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    wfill <= FULL_V);
  a_r7_full_hold: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    (wfill == FULL_V) |=> (wgray == $past(wgray)));
  a_r7_sticky: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    overflow_o |=> overflow_o);
endmodule

bind rx_elastic_buf ebuf_chk #(.AW(AW)) i_ebuf_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wr_char(wr_char), .rd_char(rd_char), .wgray(wgray), .rgray(rgray),
  .wfill(wfill), .rfill(rfill), .rd_ins(rd_ins),
  .underflow_o(underflow_o), .overflow_o(overflow_o));

// File: tb/test_rx_elastic_buf.sv
`timescale 1ns/1ps
module test_rx_elastic_buf;
  localparam logic [8:0] K = 9'h1BC;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, byp = 1'b0;
  logic       ki = 1'b1;
  logic [7:0] di = 8'hBC;
  logic       ko, unf, ovf;
  logic [7:0] dq;

  real wper = 4.0;
  bit  wrun = 1'b1, rrun = 1'b1, rec = 1'b0, chk_en = 1'b0;
  int  gmode = 0;
  int  ntot = 0, nbad = 0, out_cnt = 0;
  logic [8:0] expq [$];

  rx_elastic_buf i_rx_elastic_buf (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .bypass_i(byp),
    .char_k_i(ki), .char_d_i(di), .char_k_o(ko), .char_d_o(dq),
    .underflow_o(unf), .overflow_o(ovf));

  initial forever begin #2.0; if (rrun) rclk = ~rclk; end
  initial forever begin #(wper / 2.0); if (wrun) wclk = ~wclk; end

  task automatic chk(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] gen_char(input int mode);
    if (mode == 0) return K;
    if (mode == 1 && $urandom_range(3) == 0) return K;
    return {1'b0, 8'($urandom)};
  endfunction

  // driver: new character every falling edge of the recovered clock
  initial begin
    forever begin
      logic [8:0] c;
      @(negedge wclk);
      c = gen_char(gmode);
      {ki, di} = c;
      if (rec && c != K) expq.push_back(c);
    end
  end

  // buffered-mode monitor: data characters must match the sent order (R2)
  initial begin
    forever begin
      logic [8:0] e;
      @(posedge rclk); #1;
      if (chk_en && !byp && {ko, dq} != K) begin
        out_cnt++;
        if (expq.size() == 0) chk(1'b0, "R2 extra char", {ko, dq}, 9'h0);
        else begin
          e = expq.pop_front();
          chk({ko, dq} == e, "R2 order", {ko, dq}, e);
        end
      end
    end
  end

  task automatic do_reset();
    wrun = 1; rrun = 1; byp = 0; gmode = 0; rec = 0; chk_en = 0;
    rst_n = 0;
    repeat (4) @(posedge rclk);
    rst_n = 1;
    repeat (6) @(posedge rclk);
    expq.delete();
    out_cnt = 0;
  endtask

  task automatic rate_run(input real per, input string tag);
    wper = per;
    do_reset();
    chk_en = 1; rec = 1; gmode = 1;
    repeat (4000) @(posedge rclk);
    rec = 0; gmode = 0;
    repeat (300) @(posedge rclk);
    #1;
    chk(expq.size() == 0, "R2 all delivered", 9'(expq.size()), 9'h0);
    chk(out_cnt > 2000, "R2 throughput", 9'(out_cnt > 2000), 9'h1);
    if (per < 4.0) chk(ovf == 1'b0, tag, {8'h0, ovf}, 9'h0);
    else           chk(unf == 1'b0, tag, {8'h0, unf}, 9'h0);
    chk_en = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0a17));
    // R1: reset state
    rst_n = 0;
    repeat (3) @(posedge rclk);
    #1;
    chk({ko, dq} == K, "R1 output in reset", {ko, dq}, K);
    rst_n = 1;
    repeat (4) @(posedge rclk);
    #1;
    chk({ko, dq} == K, "R1 output after reset", {ko, dq}, K);
    chk(unf == 1'b0, "R1 underflow low", {8'h0, unf}, 9'h0);
    chk(ovf == 1'b0, "R1 overflow low", {8'h0, ovf}, 9'h0);

    // R4: recovered clock fast, commas must be shed
    rate_run(3.9, "R4 no overflow when fast");
    // R5: recovered clock slow, commas must be repeated
    rate_run(4.1, "R5 no underflow when slow");

    // R6: recovered clock stops, store drains
    wper = 4.0;
    do_reset();
    repeat (50) @(posedge rclk);
    wrun = 0;
    repeat (40) @(posedge rclk);
    #1;
    chk(unf == 1'b1, "R6 underflow set", {8'h0, unf}, 9'h1);
    chk({ko, dq} == K, "R6 comma when empty", {ko, dq}, K);
    wrun = 1;
    repeat (40) @(posedge rclk);
    #1;
    chk(unf == 1'b1, "R6 underflow sticky", {8'h0, unf}, 9'h1);
    chk(ovf == 1'b0, "R6 no overflow", {8'h0, ovf}, 9'h0);

    // R7: reference clock stops, store fills
    do_reset();
    repeat (30) @(posedge wclk);
    rrun = 0;
    chk_en = 1; rec = 1; gmode = 2;
    repeat (40) @(posedge wclk);
    rec = 0; gmode = 0;
    repeat (4) @(posedge wclk);
    #1;
    chk(ovf == 1'b1, "R7 overflow set", {8'h0, ovf}, 9'h1);
    rrun = 1;
    repeat (100) @(posedge rclk);
    #1;
    chk(out_cnt >= 4 && out_cnt <= 16, "R7 stored count", 9'(out_cnt), 9'd8);
    chk(ovf == 1'b1, "R7 overflow sticky", {8'h0, ovf}, 9'h1);
    chk_en = 0;

    // R8: bypass follows the recovered clock
    do_reset();
    byp = 1; gmode = 1;
    repeat (3) @(posedge wclk);
    for (int i = 0; i < 200; i++) begin
      logic [8:0] cur;
      @(posedge wclk);
      cur = {ki, di};
      #1;
      chk({ko, dq} == cur, "R8 bypass", {ko, dq}, cur);
    end

    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    #400000;
    ntot++; nbad++;
    $display("FAIL watchdog act=%h exp=%h", 9'h0, 9'h1);
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule